// File: doc/BRIEF.md
# I/O Page Table Translation Engine

This block turns a device DMA virtual address into a 36-bit physical address by reading one entry of a flat, single-level page table held in memory. A request brings an address and a direction flag. The engine works out where the entry for that page lives, using the table base and a translation window whose size is chosen by a 3-bit code. It then fetches that single 32-bit word over a memory read port, decodes it and checks the permission bits. The result is either a physical address with a read-only or read-write permission, or a fault.

The block does not cache entries. Each request makes exactly one memory read, and only one translation is in flight at a time. When a translation faults, the engine pushes a formatted status word and the faulting page address toward the register bank. That same pulse also raises the interrupt.

Top module: `iopt_xlate_engine`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `req_ready` is 1 and `mem_req_valid`, `rsp_valid` and `fault_push` are 0.
- R2: The table base, window code, address and direction are sampled when a request is accepted. The entry address is (table_base << 4) + (((page & ~win) >> 10) & ~3). Here page is the request address with bits [11:0] cleared, and win = ~((2^24 << code) - 1), so code 0 selects a 16 MB window and code 7 selects a 2 GB window.
- R3: The entry arrives big-endian: `mem_rsp_data[7:0]` holds entry bits [31:24], and so on up to `mem_rsp_data[31:24]`, which holds entry bits [7:0].
- R4: On success, `rsp_pa` = {entry[31:8], request address[11:0]}.
- R5: A translation faults whenever entry bit 1 (valid) is 0.
- R6: A write faults when entry bit 2 (writable) is 0. A read of such an entry succeeds.
- R7: On success, `rsp_perm_rw` equals entry bit 2. Bits 7 and 0 have no effect on the result.
- R8: The fault status word has bits 31, 30, 23 and 17 set, plus bit 18 when the access was a read, and all other bits 0. That gives 0xC0860000 for a read and 0xC0820000 for a write.
- R9: `fault_addr` is the request address with bits [11:0] cleared. `fault_push` is a one-cycle pulse on the first cycle of a faulting response and is never high otherwise.
- R10: After a request is accepted, `req_ready` stays 0 until the response has been taken.
- R11: `mem_req_valid`, once raised, stays high with `mem_req_addr` unchanged until `mem_req_ready` is seen. Exactly one memory read is issued per request.
- R12: `rsp_valid` and the response fields hold steady until `rsp_ready`. A faulting response reports `rsp_pa` = 0 and `rsp_perm_rw` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_addr | input | 32 | Device virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| tbl_base | input | 32 | Page table base (shifted left by 4 to form a byte address) |
| win_code | input | 3 | Window size code, 16 MB << code |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry word returned |
| mem_rsp_data | input | 32 | Entry word in big-endian byte lanes |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Translation faulted |
| rsp_perm_rw | output | 1 | 1 = read-write page, 0 = read-only |
| rsp_pa | output | 36 | Physical address |
| fault_push | output | 1 | Write strobe for the fault registers and interrupt raise |
| fault_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Page-aligned faulting address |

## Verification
The bench drives reads and writes against entries that cover every combination of the valid and writable bits. Comparing these cases separates the invalid-entry fault, the write-protection fault and the read-only success, and shows the direction bit landing in the status word. Entry words use distinct byte values with the cacheable and write-as-zero bits set, so a byte-lane mistake or a stray flag use shows up in the physical address or permission. Requests spread across several window codes and two table bases, including an address that differs from an earlier one only above the window, which tests the masking and the index arithmetic. Random stalls on the memory and response handshakes test the hold rules.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    localparam int VA_W        = 32;
    localparam int PA_W        = 36;
    localparam int ENT_W       = 32;
    localparam int ENT_BYTES   = ENT_W / 8;
    localparam int PG_SH       = 12;
    localparam int PPN_W       = PA_W - PG_SH;
    localparam int TBL_SH      = PA_W - VA_W;
    localparam int IDX_SH      = PG_SH - 2;
    localparam int WIN_LOG_MIN = 24;
    localparam int CODE_W      = 3;

    localparam int STS_ERR  = 31;
    localparam int STS_LATE = 30;
    localparam int STS_RSV  = 23;
    localparam int STS_RD   = 18;
    localparam int STS_FAV  = 17;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } xl_state_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             cacheable;
        logic [3:0]       spare;
        logic             wr_ok;
        logic             valid;
        logic             waz;
    } pte_t;

    typedef struct packed {
        logic            fault;
        logic            perm_rw;
        logic [PA_W-1:0] pa;
    } xl_result_t;

    function automatic logic [VA_W-1:0] window_base(input logic [CODE_W-1:0] code);
        logic [VA_W-1:0] ones;
        ones = '1;
        return ones << (WIN_LOG_MIN + int'(code));
    endfunction

    function automatic logic [VA_W-1:0] page_of(input logic [VA_W-1:0] va);
        return {va[VA_W-1:PG_SH], {PG_SH{1'b0}}};
    endfunction

    function automatic logic [31:0] fault_word(input logic is_read);
        logic [31:0] w;
        w           = '0;
        w[STS_ERR]  = 1'b1;
        w[STS_LATE] = 1'b1;
        w[STS_RSV]  = 1'b1;
        w[STS_FAV]  = 1'b1;
        w[STS_RD]   = is_read;
        return w;
    endfunction

endpackage

// File: rtl/iopt_ent_addr.sv
module iopt_ent_addr
    import iopt_pkg::*;
(
    input  logic [VA_W-1:0]   tbl_base,
    input  logic [CODE_W-1:0] win_code,
    input  logic [VA_W-1:0]   va,
    output logic [PA_W-1:0]   ent_addr
);
    logic [VA_W-1:0] win_start;
    logic [VA_W-1:0] in_win;
    logic [VA_W-1:0] idx_bytes;

    always_comb begin
        win_start = window_base(win_code);
        in_win    = page_of(va) & ~win_start;
        idx_bytes = (in_win >> IDX_SH) & ~(VA_W'(3));
        ent_addr  = {tbl_base, {TBL_SH{1'b0}}} + PA_W'(idx_bytes);
    end
endmodule

// File: rtl/iopt_ent_check.sv
module iopt_ent_check
    import iopt_pkg::*;
(
    input  logic [ENT_W-1:0] raw_word,
    input  logic [VA_W-1:0]  va,
    input  logic             is_write,
    output xl_result_t       result
);
    logic [ENT_W-1:0] native;
    pte_t             pte;

    for (genvar b = 0; b < ENT_BYTES; b++) begin : g_lane
        assign native[ENT_W-1-8*b -: 8] = raw_word[8*b +: 8];
    end

    assign pte = pte_t'(native);

    always_comb begin
        result.fault   = !pte.valid || (is_write && !pte.wr_ok);
        result.perm_rw = 1'b0;
        result.pa      = '0;
        if (!result.fault) begin
            result.perm_rw = pte.wr_ok;
            result.pa      = {pte.ppn, va[PG_SH-1:0]};
        end
    end
endmodule

// File: rtl/iopt_xlate_engine.sv
module iopt_xlate_engine
    import iopt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_addr,
    input  logic                req_write,
    input  logic [VA_W-1:0]     tbl_base,
    input  logic [CODE_W-1:0]   win_code,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [PA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [ENT_W-1:0]    mem_rsp_data,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic                rsp_fault,
    output logic                rsp_perm_rw,
    output logic [PA_W-1:0]     rsp_pa,
    output logic                fault_push,
    output logic [31:0]         fault_status,
    output logic [VA_W-1:0]     fault_addr
);
    xl_state_e       st_q;
    logic [VA_W-1:0] va_q;
    logic            wr_q;
    logic [PA_W-1:0] ea_q;
    logic            issued_q;
    xl_result_t      res_q;
    logic            push_q;
    logic [31:0]     sts_q;
    logic [VA_W-1:0] fadr_q;

    logic [PA_W-1:0] ea_w;
    xl_result_t      chk_w;

    iopt_ent_addr u_addr (
        .tbl_base (tbl_base),
        .win_code (win_code),
        .va       (req_addr),
        .ent_addr (ea_w)
    );

    iopt_ent_check u_check (
        .raw_word (mem_rsp_data),
        .va       (va_q),
        .is_write (wr_q),
        .result   (chk_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            va_q     <= '0;
            wr_q     <= 1'b0;
            ea_q     <= '0;
            issued_q <= 1'b0;
            res_q    <= '0;
            push_q   <= 1'b0;
            sts_q    <= '0;
            fadr_q   <= '0;
        end else begin
            push_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q     <= req_addr;
                        wr_q     <= req_write;
                        ea_q     <= ea_w;
                        issued_q <= 1'b0;
                        st_q     <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (!issued_q && mem_req_ready) begin
                        issued_q <= 1'b1;
                    end
                    if (issued_q && mem_rsp_valid) begin
                        res_q  <= chk_w;
                        push_q <= chk_w.fault;
                        if (chk_w.fault) begin
                            sts_q  <= fault_word(!wr_q);
                            fadr_q <= page_of(va_q);
                        end
                        st_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_FETCH) && !issued_q;
    assign mem_req_addr  = ea_q;
    assign rsp_valid     = (st_q == ST_RESP);
    assign rsp_fault     = res_q.fault;
    assign rsp_perm_rw   = res_q.perm_rw;
    assign rsp_pa        = res_q.pa;
    assign fault_push    = push_q;
    assign fault_status  = sts_q;
    assign fault_addr    = fadr_q;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R10

    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11

    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R11

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa)
                                       && $stable(rsp_fault) && $stable(rsp_perm_rw))); // R12

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && !rsp_perm_rw)); // R12

    AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
        fault_push |=> !fault_push); // R9

    AST_PUSH_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        fault_push |-> (rsp_valid && rsp_fault && !$past(rsp_valid))); // R9

    AST_STATUS_BITS: assert property (@(posedge clk) disable iff (rst)
        fault_push |-> (fault_status[STS_ERR] && fault_status[STS_LATE]
                        && fault_status[STS_RSV] && fault_status[STS_FAV])); // R8

endmodule

// File: tb/iopt_xlate_engine_tb_top.sv
module iopt_xlate_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] tbl_base = 32'h0000_1000;
    logic [2:0]  win_code = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [35:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic        rsp_perm_rw;
    logic [35:0] rsp_pa;
    logic        fault_push;
    logic [31:0] fault_status;
    logic [31:0] fault_addr;

    always #4 clk = ~clk;

    iopt_xlate_engine dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_write (req_write),
        .tbl_base (tbl_base), .win_code (win_code),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
        .rsp_fault (rsp_fault), .rsp_perm_rw (rsp_perm_rw), .rsp_pa (rsp_pa),
        .fault_push (fault_push), .fault_status (fault_status),
        .fault_addr (fault_addr)
    );

    typedef struct {
        logic [35:0] ea;
        logic        fault;
        logic        rw;
        logic [35:0] pa;
        logic [31:0] status;
        logic [31:0] faddr;
    } exp_t;

    exp_t        sb_q[$];
    logic [35:0] ea_q[$];
    logic [31:0] tab [logic [35:0]];
    int          n_chk  = 0;
    int          n_fail = 0;
    int          tick   = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] exp_ea(input logic [31:0] base,
                                           input logic [31:0] va, input logic [2:0] code);
        logic [31:0] win;
        logic [31:0] idx;
        win = ~((32'h0100_0000 << code) - 32'd1);
        idx = (((va & 32'hFFFF_F000) & ~win) >> 10) & 32'hFFFF_FFFC;
        return {base, 4'h0} + {4'h0, idx};
    endfunction

    task automatic issue(input logic [31:0] va, input bit wr,
                         input logic [2:0] code, input logic [31:0] ent);
        exp_t e;
        e.ea     = exp_ea(tbl_base, va, code);
        e.fault  = !ent[1] || (wr && !ent[2]);
        e.rw     = e.fault ? 1'b0 : ent[2];
        e.pa     = e.fault ? 36'h0 : {ent[31:8], va[11:0]};
        e.status = 32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000);
        e.faddr  = va & 32'hFFFF_F000;
        tab[e.ea] = ent;
        sb_q.push_back(e);
        ea_q.push_back(e.ea);
        @(negedge clk);
        win_code  = code;
        req_addr  = va;
        req_write = wr;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 busy after accept", 64'(req_ready), 64'd0);
    endtask

    // memory model: big-endian lanes, random accept stalls and latency
    initial begin
        int          lat = 0;
        logic [31:0] pend = '0;
        bit          hold = 0;
        logic [35:0] hold_addr = '0;
        forever begin
            @(negedge clk);
            tick++;
            mem_rsp_valid = 1'b0;
            if (hold) begin
                chk(mem_req_valid && mem_req_addr == hold_addr, "R11 request held",
                    64'(mem_req_addr), 64'(hold_addr));
                hold = 0;
            end
            mem_req_ready = 1'b0;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = {pend[7:0], pend[15:8], pend[23:16], pend[31:24]};
                end
            end else if (mem_req_valid && !rst) begin
                if ((tick % 3) != 0) begin
                    mem_req_ready = 1'b1;
                    if (ea_q.size() == 0) begin
                        chk(1'b0, "R11 unexpected fetch", 64'(mem_req_addr), 64'd0);
                    end else begin
                        logic [35:0] want;
                        want = ea_q.pop_front();
                        chk(mem_req_addr == want, "R2 entry address",
                            64'(mem_req_addr), 64'(want));
                    end
                    pend = tab.exists(mem_req_addr) ? tab[mem_req_addr] : 32'h0;
                    lat  = 2 + (tick % 4);
                end else begin
                    hold      = 1;
                    hold_addr = mem_req_addr;
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin
        bit          prev_rv = 0;
        bit          held = 0;
        logic [35:0] h_pa = '0;
        logic        h_f = 0;
        logic        h_rw = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (held) begin
                    chk(rsp_valid && rsp_pa == h_pa && rsp_fault == h_f && rsp_perm_rw == h_rw,
                        "R12 response held", 64'(rsp_pa), 64'(h_pa));
                    held = 0;
                end
                if (rsp_valid && !prev_rv && sb_q.size() > 0) begin
                    chk(fault_push == sb_q[0].fault, "R9 push pulse",
                        64'(fault_push), 64'(sb_q[0].fault));
                    if (sb_q[0].fault) begin
                        chk(fault_status == sb_q[0].status, "R8 status word",
                            64'(fault_status), 64'(sb_q[0].status));
                        chk(fault_addr == sb_q[0].faddr, "R9 fault address",
                            64'(fault_addr), 64'(sb_q[0].faddr));
                    end
                end else if (!(rsp_valid && !prev_rv)) begin
                    if (fault_push) chk(1'b0, "R9 stray push", 64'(fault_push), 64'd0);
                end
                rsp_ready = ((tick % 5) != 1);
                if (rsp_valid && rsp_ready) begin
                    if (sb_q.size() == 0) begin
                        chk(1'b0, "R12 unexpected response", 64'(rsp_pa), 64'd0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        chk(rsp_fault == e.fault, "R5 R6 fault flag",
                            64'(rsp_fault), 64'(e.fault));
                        chk(rsp_pa == e.pa, "R3 R4 physical address",
                            64'(rsp_pa), 64'(e.pa));
                        chk(rsp_perm_rw == e.rw, "R7 permission",
                            64'(rsp_perm_rw), 64'(e.rw));
                    end
                end else if (rsp_valid) begin
                    held = 1;
                    h_pa = rsp_pa;
                    h_f  = rsp_fault;
                    h_rw = rsp_perm_rw;
                end
                prev_rv = rsp_valid;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(fault_push == 1'b0, "R1 fault_push", 64'(fault_push), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && !mem_req_valid && !rsp_valid, "R1 after release",
            64'(req_ready), 64'd1);

        issue(32'hFF01_2345, 1'b0, 3'd0, 32'hABCD_E106); // R4 R7 read of rw page
        issue(32'hFF0F_F678, 1'b1, 3'd0, 32'h1234_5687); // R7 write, cache+waz set
        issue(32'hFFFF_F00C, 1'b0, 3'd0, 32'h89AB_CD02); // R6 read of ro page
        issue(32'hFF00_1ABC, 1'b1, 3'd0, 32'h5566_770B); // R6 write to ro -> fault
        issue(32'hFF00_2000, 1'b0, 3'd0, 32'hDEAD_BE04); // R5 invalid read
        issue(32'hFF00_3FFF, 1'b1, 3'd0, 32'h0000_0000); // R5 invalid write
        issue(32'h9234_5678, 1'b0, 3'd7, 32'hFEDC_BA06); // R2 2 GB window
        issue(32'hFBC0_1000, 1'b1, 3'd3, 32'h0F1E_2D86); // R2 128 MB window
        while (sb_q.size() > 0) @(negedge clk);

        tbl_base = 32'h0123_4560;
        issue(32'hE765_4321, 1'b0, 3'd5, 32'h3C4B_5A84); // R5 new base, invalid
        issue(32'hC0AB_CFFF, 1'b1, 3'd6, 32'h7766_5506); // R2 1 GB window
        while (sb_q.size() > 0) @(negedge clk);

        tbl_base = 32'h0000_1000;
        issue(32'h0001_2FED, 1'b1, 3'd0, 32'h2468_AC06); // R2 bits above window ignored
        while (sb_q.size() > 0) @(negedge clk);
        repeat (6) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule